// File: doc/BRIEF.md
# Single-Wire Bus ROM Command Dispatcher

This block is the slave-side control stage of a device on a single-wire bus. It sits above the bit-timing layer. That layer turns line activity into two things: reset events and a stream of received bits. It also asks this block for a bit whenever the master opens a read slot. The dispatcher waits for a bus reset and then collects the first command byte, least significant bit first. It then runs one of six selection commands against a 64-bit device identifier supplied on `id_code`.

The six commands are Read, Match, Skip, Resume, Fast-Skip and Fast-Match. Two flags are kept across bus resets:

- The resume flag lets a previously selected device be selected again with a single byte.
- The fast-speed flag tells the timing layer to use high-speed slots.

When a selection command succeeds, `mem_en` rises. A memory-command layer then takes the bit channels over until the next bus reset.

Both bit channels use valid/ready handshakes:

- A bit moves on a rising clock edge where valid and ready are both high.
- The bit-timing layer may hold `tx_ready` low for any number of cycles. While it does, `tx_valid` and `tx_data` stay unchanged.
- `rx_ready` is a pure function of the dispatcher state. The bit source must keep `rx_valid` and `rx_data` until the transfer happens.

Top module: `owire_rom_dispatch`

## Requirements
- R1: After `rst_n` is released, `mem_en`, `od_mode` and `tx_valid` are 0. Received bits are discarded until the first bus reset, so no command can select the device before that reset.
- R2: A bit moves on a clock edge with valid and ready both high. Bytes and identifier bits travel least significant bit first. While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` holds its value.
- R3: Any `bus_rst` pulse lowers `mem_en`, ends any transmit and returns the block to waiting for a command byte. A reset flagged as standard length (`bus_rst_std`=1) also clears `od_mode`. A short reset leaves `od_mode` unchanged.
- R4: Command 8'h33 (Read) clears the resume flag. It then offers the 64 bits of `id_code` on `tx_data`, bit 0 first. `mem_en` rises the cycle after the last bit is taken.
- R5: Command 8'h55 (Match) takes 64 bits and compares them, bit 0 first, with `id_code`. If all 64 match, it sets the resume flag and raises `mem_en`.
- R6: On the first Match bit that differs, the resume flag is cleared. The block then accepts and discards all further bits, never raises `mem_en`, and never offers a bit until the next bus reset.
- R7: Command 8'hCC (Skip) clears the resume flag and raises `mem_en` right after the command byte.
- R8: Command 8'hA5 (Resume) raises `mem_en` only if the resume flag is set. If the flag is clear, the block discards bits until the next bus reset.
- R9: Command 8'h3C (Fast-Skip) sets `od_mode`, clears the resume flag and raises `mem_en`.
- R10: Command 8'h69 (Fast-Match) sets `od_mode` right after the command byte and then compares the identifier as in R5. A full match sets the resume flag and raises `mem_en`. A mismatch clears both the resume flag and `od_mode` and then behaves as in R6.
- R11: Command 8'hF0 (Search) and every other unlisted byte make the block discard bits until the next bus reset. Neither flag changes.
- R12: `rx_ready` is low while `mem_en` is high and while Read is transmitting. In every other state it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| id_code | input | ID_W | Device identifier, bit 0 sent and compared first |
| bus_rst | input | 1 | One-cycle strobe: reset pulse detected on the bus |
| bus_rst_std | input | 1 | Qualifies `bus_rst`: pulse had standard-speed length |
| rx_valid | input | 1 | Received bit available |
| rx_ready | output | 1 | Dispatcher accepts a received bit |
| rx_data | input | 1 | Received bit value |
| tx_valid | output | 1 | Dispatcher offers a bit for a read slot |
| tx_ready | input | 1 | Timing layer takes the offered bit |
| tx_data | output | 1 | Offered bit value |
| mem_en | output | 1 | Memory-command layer owns the channels |
| od_mode | output | 1 | High-speed slot timing selected |

## Verification
The bench goes after the following corner cases:

- **Mismatch on one interior identifier bit.** A design that grants after a partial compare, or that stops accepting bits, would raise `mem_en` or stall the source.
- **Resume after each command.** Resume is tried after Match, Read, Skip, a failed Match and Search. A dispatcher that mishandles which commands touch the resume flag would grant where it must refuse, or the reverse.
- **Short versus standard-length resets in fast mode.** A design that ignores the length qualifier would leave fast mode at the wrong moment.
- **Stalls during Read.** The bench holds `tx_ready` low mid-identifier. A serializer that advances without a handshake would skip or repeat bits.

// File: rtl/owr_pkg.sv
package owr_pkg;
  localparam int CMD_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_MATCH,
    ST_SEND,
    ST_MEM,
    ST_HALT
  } owr_state_e;

  localparam logic [CMD_W-1:0] OP_READ    = 8'h33;
  localparam logic [CMD_W-1:0] OP_MATCH   = 8'h55;
  localparam logic [CMD_W-1:0] OP_SKIP    = 8'hCC;
  localparam logic [CMD_W-1:0] OP_RESUME  = 8'hA5;
  localparam logic [CMD_W-1:0] OP_FSKIP   = 8'h3C;
  localparam logic [CMD_W-1:0] OP_FMATCH  = 8'h69;
endpackage

// File: rtl/owr_byte_rx.sv
module owr_byte_rx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         shift,
  input  logic         bit_in,
  output logic         done,
  output logic [W-1:0] word
);
  localparam int CW = $clog2(W);

  logic [CW-1:0] cnt;
  logic [W-2:0]  sh;

  assign done = shift && (cnt == CW'(W - 1));
  assign word = {bit_in, sh};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      sh  <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (shift) begin
      sh  <= {bit_in, sh[W-2:1]};
      cnt <= done ? '0 : cnt + 1'b1;
    end
  end

  AST_BYTE_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !clr && !done) |=> (cnt != '0)); // R2
endmodule

// File: rtl/owr_id_index.sv
module owr_id_index #(
  parameter int ID_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            step,
  input  logic [ID_W-1:0] id_code,
  output logic            cur_bit,
  output logic            last
);
  localparam int IW = $clog2(ID_W);

  logic [IW-1:0] idx;

  assign cur_bit = id_code[idx];
  assign last    = (idx == IW'(ID_W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0;
    end else if (clr) begin
      idx <= '0;
    end else if (step) begin
      idx <= last ? '0 : idx + 1'b1;
    end
  end

  AST_ID_INDEX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last && !clr) |=> (idx == '0)); // R5
endmodule

// File: rtl/owire_rom_dispatch.sv
module owire_rom_dispatch
  import owr_pkg::*;
#(
  parameter int ID_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ID_W-1:0] id_code,
  input  logic            bus_rst,
  input  logic            bus_rst_std,
  input  logic            rx_valid,
  output logic            rx_ready,
  input  logic            rx_data,
  output logic            tx_valid,
  input  logic            tx_ready,
  output logic            tx_data,
  output logic            mem_en,
  output logic            od_mode
);
  owr_state_e       state;
  logic             resume_q;
  logic             od_q;
  logic             fmatch_q;
  logic             rx_fire;
  logic             tx_fire;
  logic             cmd_done;
  logic [CMD_W-1:0] cmd_byte;
  logic             cur_bit;
  logic             id_last;
  logic             mismatch;

  assign rx_ready = (state == ST_IDLE) || (state == ST_CMD) ||
                    (state == ST_MATCH) || (state == ST_HALT);
  assign tx_valid = (state == ST_SEND);
  assign tx_data  = cur_bit;
  assign mem_en   = (state == ST_MEM);
  assign od_mode  = od_q;
  assign rx_fire  = rx_valid && rx_ready;
  assign tx_fire  = tx_valid && tx_ready;
  assign mismatch = (rx_data != cur_bit);

  owr_byte_rx #(.W(CMD_W)) u_byte_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (bus_rst || (state != ST_CMD)),
    .shift  (rx_fire && (state == ST_CMD)),
    .bit_in (rx_data),
    .done   (cmd_done),
    .word   (cmd_byte)
  );

  owr_id_index #(.ID_W(ID_W)) u_id_index (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (bus_rst || (state == ST_CMD)),
    .step    ((rx_fire && (state == ST_MATCH)) || tx_fire),
    .id_code (id_code),
    .cur_bit (cur_bit),
    .last    (id_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      resume_q <= 1'b0;
      od_q     <= 1'b0;
      fmatch_q <= 1'b0;
    end else if (bus_rst) begin
      state    <= ST_CMD;
      fmatch_q <= 1'b0;
      if (bus_rst_std) od_q <= 1'b0;
    end else begin
      case (state)
        ST_CMD: if (cmd_done) begin
          case (cmd_byte)
            OP_READ: begin
              resume_q <= 1'b0;
              state    <= ST_SEND;
            end
            OP_MATCH: begin
              fmatch_q <= 1'b0;
              state    <= ST_MATCH;
            end
            OP_SKIP: begin
              resume_q <= 1'b0;
              state    <= ST_MEM;
            end
            OP_RESUME: state <= resume_q ? ST_MEM : ST_HALT;
            OP_FSKIP: begin
              resume_q <= 1'b0;
              od_q     <= 1'b1;
              state    <= ST_MEM;
            end
            OP_FMATCH: begin
              od_q     <= 1'b1;
              fmatch_q <= 1'b1;
              state    <= ST_MATCH;
            end
            default: state <= ST_HALT;
          endcase
        end
        ST_MATCH: if (rx_fire) begin
          if (mismatch) begin
            resume_q <= 1'b0;
            if (fmatch_q) od_q <= 1'b0;
            state <= ST_HALT;
          end else if (id_last) begin
            resume_q <= 1'b1;
            state    <= ST_MEM;
          end
        end
        ST_SEND: if (tx_fire && id_last) state <= ST_MEM;
        default: state <= state;
      endcase
    end
  end

  AST_RESET_TO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> (!mem_en && !tx_valid && rx_ready)); // R3
  AST_STD_RESET_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rst && bus_rst_std) |=> !od_mode); // R3
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !bus_rst) |=> (tx_valid && $stable(tx_data))); // R2
  AST_RESUME_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && (cmd_byte == OP_RESUME) && !resume_q && !bus_rst) |=> !mem_en); // R8
  AST_MISMATCH_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_MATCH) && rx_fire && mismatch && !bus_rst) |=> (!mem_en && !tx_valid && rx_ready)); // R6
  AST_FAST_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && (cmd_byte == OP_FSKIP) && !bus_rst) |=> (od_mode && mem_en)); // R9
endmodule

// File: tb/owire_rom_dispatch_tb.sv
module owire_rom_dispatch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ID_W = 64;
  localparam logic [ID_W-1:0] ID = 64'hA7C3_5E19_0B64_F22D;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_rst = 1'b0;
  logic            bus_rst_std = 1'b0;
  logic            rx_valid = 1'b0;
  logic            rx_data = 1'b0;
  logic            tx_ready = 1'b0;
  logic            rx_ready, tx_valid, tx_data, mem_en, od_mode;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  owire_rom_dispatch #(.ID_W(ID_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .id_code(ID),
    .bus_rst(bus_rst), .bus_rst_std(bus_rst_std),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .mem_en(mem_en), .od_mode(od_mode)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse_reset(input logic std);
    @(negedge clk);
    bus_rst = 1'b1;
    bus_rst_std = std;
    @(negedge clk);
    bus_rst = 1'b0;
    bus_rst_std = 1'b0;
  endtask

  task automatic put_bit(input logic b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) put_bit(v[i]);
  endtask

  task automatic put_id(input logic [ID_W-1:0] v);
    for (int i = 0; i < ID_W; i++) put_bit(v[i]);
  endtask

  task automatic t_powerup;
    chk("R1 mem_en", {63'd0, mem_en}, 64'd0);
    chk("R1 od_mode", {63'd0, od_mode}, 64'd0);
    chk("R1 tx_valid", {63'd0, tx_valid}, 64'd0);
    put_byte(8'hCC);
    chk("R1 no select before bus reset", {63'd0, mem_en}, 64'd0);
  endtask

  task automatic t_skip;
    pulse_reset(1'b1);
    put_byte(8'hCC);
    chk("R7 skip grants", {63'd0, mem_en}, 64'd1);
    chk("R12 rx_ready low in memory phase", {63'd0, rx_ready}, 64'd0);
    pulse_reset(1'b1);
    chk("R3 reset drops mem_en", {63'd0, mem_en}, 64'd0);
    put_byte(8'hA5);
    chk("R8 resume refused after skip", {63'd0, mem_en}, 64'd0);
  endtask

  task automatic t_match_ok;
    pulse_reset(1'b1);
    put_byte(8'h55);
    put_id(ID);
    chk("R5 match grants", {63'd0, mem_en}, 64'd1);
    pulse_reset(1'b1);
    put_byte(8'hA5);
    chk("R8 resume after match", {63'd0, mem_en}, 64'd1);
  endtask

  task automatic t_read;
    logic [ID_W-1:0] got;
    logic held;
    got = '0;
    pulse_reset(1'b1);
    put_byte(8'h33);
    chk("R12 rx_ready low while sending", {63'd0, rx_ready}, 64'd0);
    for (int i = 0; i < ID_W; i++) begin
      @(negedge clk);
      if (i == 9 || i == 40) begin
        held = tx_data;
        tx_ready = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 tx held under stall", {62'd0, tx_valid, tx_data}, {62'd0, 1'b1, held});
      end
      tx_ready = 1'b1;
      got[i] = tx_data;
      if (!tx_valid) chk("R4 tx_valid during send", 64'd0, 64'd1);
      @(posedge clk);
    end
    @(negedge clk);
    tx_ready = 1'b0;
    chk("R4 identifier LSB first", got, ID);
    chk("R4 grant after send", {63'd0, mem_en}, 64'd1);
    pulse_reset(1'b1);
    put_byte(8'hA5);
    chk("R4 read cleared resume", {63'd0, mem_en}, 64'd0);
  endtask

  task automatic t_mismatch;
    pulse_reset(1'b1);
    put_byte(8'h55);
    put_id(ID);
    pulse_reset(1'b1);
    put_byte(8'h55);
    put_id(ID ^ (64'd1 << 37));
    chk("R6 no grant on mismatch", {63'd0, mem_en}, 64'd0);
    chk("R6 no tx on mismatch", {63'd0, tx_valid}, 64'd0);
    chk("R6 bits still accepted", {63'd0, rx_ready}, 64'd1);
    pulse_reset(1'b1);
    put_byte(8'hA5);
    chk("R6 mismatch cleared resume", {63'd0, mem_en}, 64'd0);
  endtask

  task automatic t_fast_skip;
    pulse_reset(1'b1);
    put_byte(8'h3C);
    chk("R9 fast skip od_mode", {63'd0, od_mode}, 64'd1);
    chk("R9 fast skip grants", {63'd0, mem_en}, 64'd1);
    pulse_reset(1'b0);
    chk("R3 short reset keeps od_mode", {62'd0, od_mode, mem_en}, 64'd2);
    pulse_reset(1'b1);
    chk("R3 standard reset clears od_mode", {63'd0, od_mode}, 64'd0);
  endtask

  task automatic t_fast_match;
    pulse_reset(1'b1);
    put_byte(8'h69);
    chk("R10 od_mode after command byte", {63'd0, od_mode}, 64'd1);
    put_id(ID);
    chk("R10 fast match grants", {63'd0, mem_en}, 64'd1);
    pulse_reset(1'b1);
    put_byte(8'h69);
    put_id(ID ^ 64'h8000_0000_0000_0000);
    chk("R10 mismatch no grant", {63'd0, mem_en}, 64'd0);
    chk("R10 mismatch clears od_mode", {63'd0, od_mode}, 64'd0);
  endtask

  task automatic t_search;
    pulse_reset(1'b1);
    put_byte(8'h55);
    put_id(ID);
    pulse_reset(1'b1);
    put_byte(8'hF0);
    put_byte(8'hCC);
    chk("R11 search halts", {62'd0, mem_en, tx_valid}, 64'd0);
    pulse_reset(1'b1);
    put_byte(8'h00);
    chk("R11 unknown byte halts", {63'd0, mem_en}, 64'd0);
    pulse_reset(1'b1);
    put_byte(8'hA5);
    chk("R11 resume flag kept", {63'd0, mem_en}, 64'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_powerup();
    t_skip();
    t_match_ok();
    t_read();
    t_mismatch();
    t_fast_skip();
    t_fast_match();
    t_search();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule